// File: doc/BRIEF.md
# Register-Driven Two-Wire EEPROM Byte Access Engine

This block gives a host single-byte read and write access to a serial two-wire EEPROM through two 32-bit registers on a simple synchronous register port. The host puts a 16-bit byte address and a direction bit in the command register, sets the start bit, and polls that bit until hardware clears it. Before a write it loads the byte to send into the data register. After a read it finds the byte returned by the device in the same register.

The engine produces the clock line from the system clock with a programmable divider and drives the data line open-drain. A write runs START, device address with write bit, address high byte, address low byte, data byte, STOP. A read runs START, device address with write bit, the two address bytes, a repeated START, device address with read bit, one received byte answered with NAK, and STOP.

If the device fails to acknowledge at any point, the engine ends the attempt with STOP and replays the whole sequence. A third failure raises a sticky error flag. When reset is released, the engine reads one configured address on its own, places the byte in the data register, and then raises a done flag.

Top module: `eeprom_regport`

## Requirements
- R1: Both registers read zero during reset. In the command register, bits [31:29], [26] and [23:16] always read zero, and writes to them, or to the read-only bit 27, change nothing. In the data register, bits [31:8] read zero.
- R2: The command register is at offset 0x58, with address in [15:0], direction in [24] (1 = read, 0 = write), start in [25], init-done in [27] and error in [28]. The data register is at offset 0x5C, with the byte in [7:0]. Every other offset reads zero.
- R3: A write sends START, {device address, 0}, address[15:8], address[7:0], data byte, STOP, each byte MSB first. With no NAK, start clears exactly 152*DIV cycles after the write that set it.
- R4: A read sends START, {device address, 0}, address[15:8], address[7:0], repeated START, {device address, 1}, receives one byte, answers it with NAK, then sends STOP. With no NAK, start clears exactly 192*DIV cycles after it was set, and the data register then holds the received byte.
- R5: A NAK at any acknowledge point ends the attempt with STOP and restarts the full sequence. An operation that succeeds on its second or third attempt leaves the error flag clear.
- R6: After the third failed attempt, the error flag is set and start clears. The data register keeps its value, and both bus lines are left released high.
- R7: The error flag clears only when 1 is written to bit 28. Writing 0 to bit 28 leaves it set.
- R8: Once reset is released, the engine reads address INIT_ADDR into the data register and then sets init-done, which stays set. A start written during this pass is ignored, and so are the address and direction written with it.
- R9: While an operation is in progress, writes to the command register's address, direction and start fields, and writes to the data register, are ignored.
- R10: SCL runs at 4*DIV system clocks per bit. SDA changes while SCL is high only to form START or STOP. An idle bus leaves both lines high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| scl_o | output | 1 | Serial clock line |
| sda_low_o | output | 1 | 1 pulls the data line low, 0 releases it |
| sda_i | input | 1 | Sensed level of the data line |

## Verification
Each operation's result becomes visible on the same edge that clears start. Without NAKs, that edge comes 152*DIV cycles after the start write for a write and 192*DIV cycles after it for a read. The bench samples the command register half a cycle after each edge, counts the cycles during which start reads 1, and compares that count with these exact figures. It reads the data register, the error flag and the device model's memory only after start has been seen low. Register writes take effect on the next edge, so all readbacks happen on the following half cycle.

// File: rtl/eeprom_regport.sv
module eeprom_regport #(
  parameter int          DIV       = 250,
  parameter logic [6:0]  DEV_ADDR  = 7'h50,
  parameter logic [15:0] INIT_ADDR = 16'h0000,
  parameter logic [7:0]  CMD_OFS   = 8'h58,
  parameter logic [7:0]  DATA_OFS  = 8'h5C
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        scl_o,
  output logic        sda_low_o,
  input  logic        sda_i
);

  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [1:0] LAST_TRY = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_START, S_BIT, S_STOP} seg_t;

  seg_t        seg;
  logic [1:0]  q;
  logic [DW-1:0] div_cnt;
  logic [3:0]  bitn;
  logic [2:0]  step;
  logic [1:0]  tries;
  logic        nak_q;
  logic [7:0]  rx_q;
  logic        run, init_run;
  logic        start_q, dir_q, done_q, err_q;
  logic [15:0] addr_q;
  logic [7:0]  data_q;
  logic [7:0]  cur_byte;
  logic        scl_w, sda_w;

  wire tick    = run && (div_cnt == DW'(DIV - 1));
  wire end_seg = tick && (q == 2'd3);
  wire smp     = tick && (q == 2'd1);
  wire op_rd   = init_run | dir_q;
  wire [15:0] op_addr = init_run ? INIT_ADDR : addr_q;
  wire recv    = op_rd && (step == 3'd4);
  wire ack_bit = (bitn == 4'd8);
  wire cmd_wr  = reg_wr && (reg_addr == CMD_OFS);
  wire dat_wr  = reg_wr && (reg_addr == DATA_OFS);

  always_comb begin
    case (step)
      3'd0:    cur_byte = {DEV_ADDR, 1'b0};
      3'd1:    cur_byte = op_addr[15:8];
      3'd2:    cur_byte = op_addr[7:0];
      3'd3:    cur_byte = op_rd ? {DEV_ADDR, 1'b1} : data_q;
      default: cur_byte = 8'hFF;
    endcase
  end

  wire tx_bit = (ack_bit || recv) ? 1'b1 : cur_byte[3'd7 - bitn[2:0]];

  always_comb begin
    case (seg)
      S_START: begin scl_w = (q == 2'd1) || (q == 2'd2); sda_w = (q < 2'd2);  end
      S_BIT:   begin scl_w = (q == 2'd1) || (q == 2'd2); sda_w = tx_bit;      end
      S_STOP:  begin scl_w = (q != 2'd0);                sda_w = (q >= 2'd2); end
      default: begin scl_w = 1'b1;                       sda_w = 1'b1;        end
    endcase
  end

  assign scl_o     = scl_w;
  assign sda_low_o = !sda_w;

  assign reg_rdata = (reg_addr == CMD_OFS)  ? {3'b0, err_q, done_q, 1'b0, start_q, dir_q, 8'h00, addr_q} :
                     (reg_addr == DATA_OFS) ? {24'h0, data_q} : 32'h0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg      <= S_START;
      q        <= '0;
      div_cnt  <= '0;
      bitn     <= '0;
      step     <= '0;
      tries    <= '0;
      nak_q    <= 1'b0;
      rx_q     <= '0;
      run      <= 1'b1;
      init_run <= 1'b1;
      start_q  <= 1'b0;
      dir_q    <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
    end else begin
      if (cmd_wr && reg_wdata[28]) err_q <= 1'b0;
      if (cmd_wr && !run) begin
        addr_q <= reg_wdata[15:0];
        dir_q  <= reg_wdata[24];
        if (reg_wdata[25]) begin
          start_q <= 1'b1;
          run     <= 1'b1;
          seg     <= S_START;
          q       <= '0;
          div_cnt <= '0;
          step    <= '0;
          tries   <= '0;
          bitn    <= '0;
          nak_q   <= 1'b0;
        end
      end
      if (dat_wr && !run) data_q <= reg_wdata[7:0];

      if (run) begin
        div_cnt <= tick ? '0 : div_cnt + 1'b1;
        if (tick) q <= q + 1'b1;
        if (smp && seg == S_BIT) begin
          if (ack_bit && !recv) nak_q <= sda_i;
          else if (!ack_bit && recv) rx_q <= {rx_q[6:0], sda_i};
        end
        if (end_seg) begin
          case (seg)
            S_START: begin
              seg  <= S_BIT;
              bitn <= '0;
            end
            S_BIT: begin
              if (!ack_bit)                  bitn <= bitn + 1'b1;
              else if (recv || nak_q)        seg  <= S_STOP;
              else if (!op_rd && step == 3'd3) seg <= S_STOP;
              else if (op_rd && step == 3'd2) begin
                seg  <= S_START;
                step <= 3'd3;
              end else begin
                step <= step + 1'b1;
                bitn <= '0;
              end
            end
            S_STOP: begin
              if (nak_q && tries != LAST_TRY) begin
                tries <= tries + 1'b1;
                seg   <= S_START;
                step  <= '0;
                nak_q <= 1'b0;
              end else begin
                if (nak_q) err_q <= 1'b1;
                else if (op_rd) data_q <= rx_q;
                run     <= 1'b0;
                start_q <= 1'b0;
                seg     <= S_IDLE;
                if (init_run) begin
                  init_run <= 1'b0;
                  done_q   <= 1'b1;
                end
              end
            end
            default: seg <= S_IDLE;
          endcase
        end
      end
    end
  end

  AST_SDA_HOLD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (seg == S_BIT && scl_o && $past(scl_o)) |-> $stable(sda_low_o)); // R10
  AST_START_IMPLIES_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> run); // R9
  AST_DATA_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> $stable(data_q)); // R9
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(done_q) |-> done_q); // R8
  AST_ERR_AT_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $fell(run)); // R6
  AST_TRY_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    tries <= LAST_TRY); // R5

endmodule

// File: tb/eeprom_regport_tb.sv
module eeprom_regport_tb_top;
  localparam int DIV = 4;
  localparam logic [15:0] INIT_A = 16'h0012;
  localparam logic [7:0] CMD = 8'h58;
  localparam logic [7:0] DAT = 8'h5C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic scl, sda_low, sl_low;
  wire sda_bus = !(sda_low || sl_low);

  always #4 clk = ~clk;

  eeprom_regport #(.DIV(DIV), .DEV_ADDR(7'h50), .INIT_ADDR(INIT_A)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .scl_o(scl), .sda_low_o(sda_low), .sda_i(sda_bus));

  int n_chk = 0;
  int n_fail = 0;

  logic [7:0] mem [0:255];
  typedef enum {SL_IDLE, SL_DEV, SL_AHI, SL_ALO, SL_WD, SL_RD} sl_t;
  sl_t sl_st = SL_IDLE;
  sl_t nxt = SL_IDLE;
  int cnt = 0;
  logic [7:0] sh = '0, ahi = '0, alo = '0;
  logic scl_p = 1'b1, sda_p = 1'b1;
  int nak_left = 0, attempts = 0, wr_count = 0;
  logic [15:0] last_wr = '0, last_rd = '0;

  initial begin
    sl_low = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'hA5;
  end

  always @(negedge clk) begin
    if (scl_p && scl && sda_p && !sda_bus) begin
      sl_st = SL_DEV; cnt = 0; sl_low = 1'b0;
    end else if (scl_p && scl && !sda_p && sda_bus) begin
      sl_st = SL_IDLE; sl_low = 1'b0;
    end else if (!scl_p && scl) begin
      if (sl_st != SL_IDLE && sl_st != SL_RD && cnt < 8) begin
        sh = {sh[6:0], sda_bus}; cnt++;
      end
    end else if (scl_p && !scl) begin
      if (sl_st == SL_RD) begin
        if (cnt < 8) begin sl_low = !mem[alo][7 - cnt]; cnt++; end
        else if (cnt == 8) begin sl_low = 1'b0; cnt = 9; end
      end else if (sl_st != SL_IDLE) begin
        if (cnt == 8) begin
          cnt = 9;
          case (sl_st)
            SL_DEV: begin
              if (!sh[0]) attempts++;
              if (sh[7:1] == 7'h50 && nak_left == 0) begin
                sl_low = 1'b1;
                nxt = sh[0] ? SL_RD : SL_AHI;
                if (sh[0]) last_rd = {ahi, alo};
              end else begin
                if (nak_left > 0) nak_left--;
                nxt = SL_IDLE;
              end
            end
            SL_AHI: begin ahi = sh; sl_low = 1'b1; nxt = SL_ALO; end
            SL_ALO: begin alo = sh; sl_low = 1'b1; nxt = SL_WD; end
            default: begin
              mem[alo] = sh; last_wr = {ahi, alo}; wr_count++;
              sl_low = 1'b1; nxt = SL_IDLE;
            end
          endcase
        end else if (cnt == 9) begin
          sl_low = 1'b0; cnt = 0; sl_st = nxt;
          if (nxt == SL_RD) begin sl_low = !mem[alo][7]; cnt = 1; end
        end
      end
    end
    scl_p = scl;
    sda_p = sda_bus;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle(output int cyc, output int rises);
    logic sp;
    cyc = 0; rises = 0;
    reg_addr = CMD;
    #1 sp = scl;
    while (reg_rdata[25] && cyc < 20000) begin
      cyc++;
      @(negedge clk);
      #1;
      if (scl && !sp) rises++;
      sp = scl;
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    reg_read(CMD, v); chk("R1 cmd in reset", v, 32'h0);
    reg_read(DAT, v); chk("R1 data in reset", v, 32'h0);
  endtask

  task automatic t_init;
    logic [31:0] v;
    int guard = 0;
    @(negedge clk); rst_n = 1'b1;
    reg_write(CMD, 32'h0200_0099);
    reg_addr = CMD;
    #1;
    while (!reg_rdata[27] && guard < 20000) begin @(negedge clk); #1; guard++; end
    reg_read(CMD, v); chk("R8 cmd after init, start ignored", v, 32'h0800_0000);
    reg_read(DAT, v); chk("R8 init byte", v, {24'h0, mem[INIT_A[7:0]]});
    chk("R8 no write during init", wr_count, 0);
  endtask

  task automatic t_write;
    logic [31:0] v;
    int c, r, a0;
    a0 = attempts;
    reg_write(DAT, 32'h0000_003C);
    reg_write(CMD, 32'h0200_1234);
    wait_idle(c, r);
    chk("R3 write duration", c, 152 * DIV);
    chk("R10 scl pulses per write", r, 38);
    chk("R3 write address", last_wr, 32'h1234);
    chk("R3 write byte", mem[8'h34], 8'h3C);
    chk("R3 single attempt", attempts - a0, 1);
  endtask

  task automatic t_read;
    logic [31:0] v;
    int c, r;
    reg_write(CMD, 32'h0300_0077);
    wait_idle(c, r);
    chk("R4 read duration", c, 192 * DIV);
    reg_read(DAT, v); chk("R4 read byte", v, {24'h0, mem[8'h77]});
    chk("R4 read address", last_rd, 32'h0077);
    reg_read(CMD, v); chk("R2 cmd fields after read", v, 32'h0900_0077);
  endtask

  task automatic t_busy;
    logic [31:0] v;
    int c, r;
    reg_write(DAT, 32'h11);
    reg_write(CMD, 32'h0200_0040);
    reg_write(CMD, 32'h0300_0055);
    reg_write(DAT, 32'h99);
    wait_idle(c, r);
    chk("R9 address kept", last_wr, 32'h0040);
    chk("R9 byte kept", mem[8'h40], 8'h11);
    reg_read(CMD, v); chk("R9 cmd unchanged", v, 32'h0800_0040);
    reg_read(DAT, v); chk("R9 data unchanged", v, 32'h11);
  endtask

  task automatic t_retry;
    logic [31:0] v;
    int c, r, a0;
    a0 = attempts;
    nak_left = 2;
    reg_write(CMD, 32'h0300_0005);
    wait_idle(c, r);
    chk("R5 three attempts", attempts - a0, 3);
    reg_read(CMD, v); chk("R5 error clear", v[28], 1'b0);
    reg_read(DAT, v); chk("R5 byte after retry", v, {24'h0, mem[8'h05]});
  endtask

  task automatic t_fail;
    logic [31:0] v;
    int c, r, a0;
    reg_write(DAT, 32'h5A);
    a0 = attempts;
    nak_left = 3;
    reg_write(CMD, 32'h0300_0006);
    wait_idle(c, r);
    chk("R6 attempts", attempts - a0, 3);
    reg_read(CMD, v); chk("R6 error set, start clear", v, 32'h1900_0006);
    reg_read(DAT, v); chk("R6 data unchanged", v, 32'h5A);
    chk("R6 bus idle", {scl, sda_bus}, 2'b11);
    reg_write(CMD, 32'h0100_0006);
    reg_read(CMD, v); chk("R7 write 0 keeps error", v[28], 1'b1);
    reg_write(CMD, 32'h1000_0006);
    reg_read(CMD, v); chk("R7 write 1 clears error", v[28], 1'b0);
  endtask

  task automatic t_reserved;
    logic [31:0] v;
    reg_write(CMD, 32'hE8FF_ABCD);
    reg_read(CMD, v); chk("R1 reserved cmd bits", v, 32'h0800_ABCD);
    reg_write(DAT, 32'hFFFF_FFAA);
    reg_read(DAT, v); chk("R1 reserved data bits", v, 32'h0000_00AA);
    reg_read(8'h60, v); chk("R2 unused offset", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_init();
    t_write();
    t_read();
    t_busy();
    t_retry();
    t_fail();
    t_reserved();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule